// File: doc/BRIEF.md
# Systolic Horner Polynomial Pipeline

The block evaluates a fixed polynomial of degree `DEGREE` at a stream of input points. Evaluation uses Horner's rule and is spread over a one-dimensional chain of cells. Each step of the rule uses two cells side by side. The first cell multiplies the running partial result by the sample's x and hands the product on. The second cell adds one coefficient and hands the sum to the next pair. The chain is seeded with the leading coefficient. Every cell is a register stage, so the whole chain advances once per clock.

Each x value moves through its own register chain next to its partial result, so every multiply cell sees the point that belongs to the result it is working on. A new x can enter on every clock. A valid bit travels with each sample, and the result leaves the last add cell as a registered output. Coefficients are written one at a time through a small configuration port. A write is honoured only while no sample is in flight.

Top module: `horner_pipe`

## Requirements
- R1: After reset, `y_valid` is low and every coefficient is zero, so any sample sent before a coefficient write yields `y_data` = 0.
- R2: For a sample with value x, `y_data` equals ((a_D·x + a_{D−1})·x + … + a_1)·x + a_0, where D is `DEGREE` and every a_j is the coefficient stored at index j. This holds for x = 0 (result a_0), x = 1 and x = −1.
- R3: The result of a sample presented with `x_valid` high in clock cycle c appears with `y_valid` high in cycle c + 2·`DEGREE`, and in no other cycle.
- R4: One sample is accepted per clock. Back-to-back and gapped input patterns leave the block in the same order and with the same spacing as they entered.
- R5: Every multiply and every add keeps only the low `W` bits of its two's-complement result, so overflow wraps around.
- R6: A configuration write with `cfg_idx` = j stores `cfg_data` as a_j. Index 0 is the constant term and index `DEGREE` is the leading coefficient that seeds the chain. An index above `DEGREE` is ignored.
- R7: A configuration write is ignored if `x_valid` is high in the same cycle, or if any sample is still inside the chain. Later results use the coefficients held before the write.
- R8: `y_valid` stays low whenever no sample is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_valid | input | 1 | Qualifies `x_data` in this cycle |
| x_data | input | W | Point at which the polynomial is evaluated, two's complement |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | clog2(DEGREE+1), at least 1 | Coefficient index j (power of x) |
| cfg_data | input | W | Coefficient value, two's complement |
| y_valid | output | 1 | Qualifies `y_data` |
| y_data | output | W | Polynomial value, wrapped to W bits |

## Verification
Every result is due exactly 2·`DEGREE` clocks after the cycle in which its x was presented. The bench stamps each sample with the cycle number at the moment it drives it, and keeps the expected value beside the stamp. When `y_valid` is seen, it checks both the value and the elapsed cycles, so a result that arrives one stage early or late fails even if its value is right. Inputs change on the falling edge and outputs are read on the falling edge, half a period away from the capturing edge. Rejected coefficient writes are checked through later results: after the chain drains, fresh samples must still match the coefficients held before the write.

// File: rtl/horner_pkg.sv
package horner_pkg;

  // Width of an index that can address n_coef entries (never narrower than one bit).
  function automatic int unsigned idx_bits(input int unsigned n_coef);
    return (n_coef <= 2) ? 1 : $clog2(n_coef);
  endfunction

endpackage

// File: rtl/horner_coef_bank.sv
module horner_coef_bank
  import horner_pkg::*;
#(
  parameter int unsigned DEGREE = 3,
  parameter int unsigned W      = 16,
  parameter int unsigned IW     = idx_bits(DEGREE + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busy,
  input  logic                      we,
  input  logic [IW-1:0]             idx,
  input  logic [W-1:0]              wdata,
  output logic [(DEGREE+1)*W-1:0]   coef_flat
);

  localparam int unsigned NCOEF = DEGREE + 1;

  // All coefficients are read in parallel every cycle, so they live in flops.
  logic [W-1:0] coef_q [NCOEF];
  logic         accept;

  assign accept = we && !busy && (32'(idx) <= DEGREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < int'(NCOEF); j++) coef_q[j] <= '0;
    end else if (accept) begin
      coef_q[idx] <= wdata;
    end
  end

  for (genvar j = 0; j < int'(NCOEF); j++) begin : g_flat
    assign coef_flat[j*W +: W] = coef_q[j];
  end

  // A write attempted while samples are in flight must not move any coefficient.
  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(coef_flat)); // R7

endmodule

// File: rtl/horner_mul_cell.sv
module horner_mul_cell #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] p_i,
  output logic         v_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] p_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic         v_q;
  logic [W-1:0] x_q;
  logic [W-1:0] p_q;
  logic [W-1:0] prod_lo;

  // The low W bits of a product are the same for signed and unsigned operands.
  assign prod_lo = p_i * x_i;

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      x_q <= x_i;
      p_q <= prod_lo;
    end
  end

  assign v_o = v_q;
  assign x_o = x_q;
  assign p_o = p_q;

  AST_MUL_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (v_i && x_i == ZERO) |=> (p_o == ZERO)); // R2
  AST_MUL_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (v_i && x_i == ONE) |=> (p_o == $past(p_i))); // R2
  AST_MUL_BY_NEG_ONE: assert property (@(posedge clk) disable iff (rst)
    (v_i && x_i == '1) |=> (p_o == ZERO - $past(p_i))); // R5

endmodule

// File: rtl/horner_add_cell.sv
module horner_add_cell #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] k_i,
  output logic         v_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] p_o
);

  logic         v_q;
  logic [W-1:0] x_q;
  logic [W-1:0] p_q;
  logic [W-1:0] sum;

  assign sum = p_i + k_i;  // wraps at W bits

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      x_q <= x_i;
      p_q <= sum;
    end
  end

  assign v_o = v_q;
  assign x_o = x_q;
  assign p_o = p_q;

  AST_ADD_ZERO_COEF: assert property (@(posedge clk) disable iff (rst)
    (v_i && k_i == '0) |=> (p_o == $past(p_i))); // R2

endmodule

// File: rtl/horner_pipe.sv
module horner_pipe
  import horner_pkg::*;
#(
  parameter  int unsigned DEGREE = 3,
  parameter  int unsigned W      = 16,
  localparam int unsigned IW     = idx_bits(DEGREE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_valid,
  input  logic [W-1:0]  x_data,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [W-1:0]  cfg_data,
  output logic          y_valid,
  output logic [W-1:0]  y_data
);

  localparam int unsigned NSTAGE = 2 * DEGREE;

  logic [(DEGREE+1)*W-1:0] coef_flat;
  logic [NSTAGE-1:0]       stage_v;
  logic                    busy;

  // Signals at pair boundaries: index k feeds pair k, index k+1 leaves it.
  logic [DEGREE:0] bnd_v;
  logic [W-1:0]    bnd_p [DEGREE+1];
  logic [W-1:0]    bnd_x [DEGREE];

  assign busy = x_valid | (|stage_v);

  horner_coef_bank #(
    .DEGREE (DEGREE),
    .W      (W),
    .IW     (IW)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .we        (cfg_we),
    .idx       (cfg_idx),
    .wdata     (cfg_data),
    .coef_flat (coef_flat)
  );

  // Seed: the leading coefficient is the starting partial result.
  assign bnd_v[0] = x_valid;
  assign bnd_x[0] = x_data;
  assign bnd_p[0] = coef_flat[DEGREE*W +: W];

  for (genvar k = 0; k < int'(DEGREE); k++) begin : g_pair
    logic         mid_v;
    logic [W-1:0] mid_x;
    logic [W-1:0] mid_p;
    logic [W-1:0] out_x;

    horner_mul_cell #(.W(W)) u_mul (
      .clk (clk),
      .rst (rst),
      .v_i (bnd_v[k]),
      .x_i (bnd_x[k]),
      .p_i (bnd_p[k]),
      .v_o (mid_v),
      .x_o (mid_x),
      .p_o (mid_p)
    );

    horner_add_cell #(.W(W)) u_add (
      .clk (clk),
      .rst (rst),
      .v_i (mid_v),
      .x_i (mid_x),
      .p_i (mid_p),
      .k_i (coef_flat[(int'(DEGREE)-1-k)*W +: W]),
      .v_o (bnd_v[k+1]),
      .x_o (out_x),
      .p_o (bnd_p[k+1])
    );

    assign stage_v[2*k]   = mid_v;
    assign stage_v[2*k+1] = bnd_v[k+1];

    if (k < int'(DEGREE) - 1) begin : g_fwd_x
      assign bnd_x[k+1] = out_x;
    end else begin : g_tail_x
      logic unused_tail_x;
      assign unused_tail_x = ^out_x;
    end
  end

  assign y_valid = bnd_v[DEGREE];
  assign y_data  = bnd_p[DEGREE];

  // A result can only leave if something was in the chain the cycle before.
  AST_OUT_NEEDS_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> $past(busy)); // R8

endmodule

// File: tb/horner_pipe_tb.sv
`timescale 1ns/1ps
module horner_pipe_tb;

  localparam int unsigned DEG = 3;
  localparam int unsigned W   = 16;
  localparam int unsigned IW  = horner_pkg::idx_bits(DEG + 1);
  localparam int          LAT = 2 * DEG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          x_valid = 1'b0;
  logic [W-1:0]  x_data = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [W-1:0]  cfg_data = '0;
  logic          y_valid;
  logic [W-1:0]  y_data;

  always #2 clk = ~clk;  // 250 MHz

  horner_pipe #(.DEGREE(DEG), .W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .x_valid  (x_valid),
    .x_data   (x_data),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data),
    .y_valid  (y_valid),
    .y_data   (y_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] mdl [DEG+1];
  logic [W-1:0] exp_y   [512];
  int           exp_c   [512];
  string        exp_tag [512];
  int wr = 0, rd = 0;
  int checks = 0, errors = 0;

  function automatic logic [W-1:0] ref_eval(input logic [W-1:0] x);
    logic [W-1:0] acc;
    acc = mdl[DEG];
    for (int k = int'(DEG) - 1; k >= 0; k--) begin
      acc = acc * x;
      acc = acc + mdl[k];
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic send(input int xi, input string tag,
                      input bit try_load = 1'b0, input int li = 0, input int lv = 0);
    @(negedge clk);
    x_valid  = 1'b1;
    x_data   = W'(xi);
    cfg_we   = try_load;
    cfg_idx  = IW'(li);
    cfg_data = W'(lv);
    exp_y[wr]   = ref_eval(W'(xi));
    exp_c[wr]   = cyc;
    exp_tag[wr] = tag;
    wr++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      x_valid = 1'b0;
      cfg_we  = 1'b0;
    end
  endtask

  task automatic drain();
    idle(LAT + 2);
  endtask

  task automatic load(input int j, input int v);
    @(negedge clk);
    x_valid  = 1'b0;
    cfg_we   = 1'b1;
    cfg_idx  = IW'(j);
    cfg_data = W'(v);
    if (j <= int'(DEG)) mdl[j] = W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Output monitor: value and arrival cycle of every result.
  always @(negedge clk) begin
    if (!rst && y_valid) begin
      if (rd >= wr) begin
        check(1'b0, "R8", "result with nothing in flight", longint'(y_data), 0);
      end else begin
        check(y_data == exp_y[rd], exp_tag[rd], "y_data",
              longint'($signed(y_data)), longint'($signed(exp_y[rd])));
        check(cyc - exp_c[rd] == LAT, "R3", "latency",
              longint'(cyc - exp_c[rd]), longint'(LAT));
        rd++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j <= int'(DEG); j++) mdl[j] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: quiet output after reset, zero coefficients
    repeat (3) begin
      @(negedge clk);
      check(y_valid == 1'b0, "R1", "y_valid after reset", longint'(y_valid), 0);
    end
    send(-3, "R1"); send(0, "R1"); send(5, "R1"); send(1, "R1");
    drain();

    // R2: back-to-back sweep with mixed-sign coefficients (covers 0, 1, -1)
    load(0, -2); load(1, 7); load(2, -5); load(3, 3);
    for (int xi = -40; xi <= 40; xi++) send(xi, "R2");
    drain();

    // R4: gapped pattern must keep order and spacing
    for (int i = 0; i < 12; i++) begin
      send(i * 3 - 17, "R4");
      if (i % 3 == 0) idle(1);
      if (i % 4 == 1) idle(2);
    end
    drain();

    // R6: leading coefficient alone, then constant term alone
    load(0, 0); load(1, 0); load(2, 0); load(3, 2);
    for (int xi = -5; xi <= 5; xi++) send(xi, "R6");
    drain();
    load(3, 0); load(0, 1234);
    send(-7, "R6"); send(0, "R6"); send(9, "R6");
    drain();

    // R5: wraparound with extreme values
    load(0, 16'h8000); load(1, -1); load(2, 16'h1234); load(3, 16'h7fff);
    send(300, "R5"); send(-300, "R5"); send(32767, "R5"); send(-32768, "R5");
    send(181, "R5"); send(0, "R5"); send(1, "R5"); send(-1, "R5");
    drain();

    // R7: writes alongside x_valid, and while samples are only in flight
    for (int i = 0; i < 5; i++) send(i + 2, "R7", 1'b1, 0, 999);
    send(11, "R7");
    @(negedge clk);
    x_valid = 1'b0; cfg_we = 1'b1; cfg_idx = IW'(3); cfg_data = W'(77);
    @(negedge clk);
    cfg_we = 1'b0;
    drain();
    send(-2, "R7"); send(3, "R7"); send(1, "R7"); send(-1, "R7");
    drain();

    // R8: long idle stretch keeps the output quiet
    repeat (20) begin
      @(negedge clk);
      check(y_valid == 1'b0, "R8", "y_valid while idle", longint'(y_valid), 0);
    end
    check(rd == wr, "R4", "results delivered", longint'(rd), longint'(wr));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule